// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Token Bank

This block holds a small bank of token latches that two independent ports, called left and right, use to agree on who may touch a shared resource. A port reaches the bank by raising its semaphore select instead of a memory enable. It picks one latch with the low bits of its address and writes a token value to claim or give back the latch. A read tells the port whether it is the current holder. At any moment a latch belongs to at most one port, and holding it means the guarded resource is in use.

A claim on a latch that the other side holds is not lost. It is kept as a pending request and is served as soon as the holder gives the latch back. When both sides claim the same free latch in the same cycle, the left port wins and the right claim waits. Everything is synchronous to one clock. Read results are registered and appear one cycle after the read is issued.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every latch is free, no request is pending, and both read-data outputs are all ones.
- R2: A write with select high and data bit 0 equal to 0 claims the addressed free latch for that port. A later read returns all zeros to the holder and all ones to the other port.
- R3: Only address bits [2:0] choose the latch and only data bit 0 carries the token. The upper address and data bits have no effect, and every bit of the read data equals the token status.
- R4: No latch is ever held by both ports at once.
- R5: When both ports claim the same free latch in the same cycle, the left port becomes the holder and the right claim stays pending.
- R6: A claim made while the other port holds the latch stays pending. It is granted in the same clock edge at which the holder writes 1 (release).
- R7: A release (data bit 0 equal to 1) by the holder frees the latch when nothing is pending, after which both ports read all ones.
- R8: A release by the non-holder withdraws that port's pending claim and leaves the holder unchanged. The withdrawn claim is not granted later.
- R9: A write with select low changes nothing, and a read needs select and output enable high with write enable low. The read result is registered for exactly one cycle, and the output is all ones in any cycle that does not follow a read.
- R10: Each latch is independent. Claiming or releasing one latch leaves the owner of every other latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left port semaphore select |
| l_we | input | 1 | Left port write enable |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | ADDR_W (12) | Left port address, bits [2:0] pick the latch |
| l_wdata | input | DATA_W (16) | Left port write data, bit 0 is the token |
| l_rdata | output | DATA_W (16) | Left port registered read data |
| r_sem_sel | input | 1 | Right port semaphore select |
| r_we | input | 1 | Right port write enable |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | ADDR_W (12) | Right port address, bits [2:0] pick the latch |
| r_wdata | input | DATA_W (16) | Right port write data, bit 0 is the token |
| r_rdata | output | DATA_W (16) | Right port registered read data |

## Verification
Claims are tried in four orders. A single uncontested claim checks basic granting. A same-cycle claim by both ports separates the fixed left priority from a symmetric or right-first choice. A claim against a held latch followed by the holder's release separates automatic handoff from simply freeing the latch. A claim followed by a release from the waiting port separates withdrawal from a stale grant. Writes and reads with the upper address and data bits set, with select low, or with output enable low show which inputs the decoder ignores. Two latches held by opposite ports show that the latches do not interfere.

// File: rtl/sem_tok_pkg.sv
package sem_tok_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'b00,
        OWN_LEFT  = 2'b01,
        OWN_RIGHT = 2'b10
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   pend_l;
        logic   pend_r;
    } cell_t;

    localparam cell_t CELL_RESET = '{owner: OWN_NONE, pend_l: 1'b0, pend_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int SEL_W   = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               we,
    input  logic               oe,
    input  logic [SEL_W-1:0]   addr_lo,
    input  logic               token,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel,
    output logic               rd_en,
    output logic [SEL_W-1:0]   rd_idx
);

    logic wr_en;

    assign wr_en  = sel & we;
    assign rd_en  = sel & oe & ~we;
    assign rd_idx = addr_lo;

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
        logic hit;
        assign hit    = wr_en && (addr_lo == SEL_W'(i));
        assign req[i] = hit & ~token;
        assign rel[i] = hit &  token;
    end

endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
    import sem_tok_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;

        // record or withdraw claims
        if (req_l && cell_q.owner != OWN_LEFT)  cell_d.pend_l = 1'b1;
        if (rel_l)                              cell_d.pend_l = 1'b0;
        if (req_r && cell_q.owner != OWN_RIGHT) cell_d.pend_r = 1'b1;
        if (rel_r)                              cell_d.pend_r = 1'b0;

        // holder gives back
        if (cell_q.owner == OWN_LEFT  && rel_l) cell_d.owner = OWN_NONE;
        if (cell_q.owner == OWN_RIGHT && rel_r) cell_d.owner = OWN_NONE;

        // grant a free latch, left first
        if (cell_d.owner == OWN_NONE) begin
            if (cell_d.pend_l) begin
                cell_d.owner  = OWN_LEFT;
                cell_d.pend_l = 1'b0;
            end else if (cell_d.pend_r) begin
                cell_d.owner  = OWN_RIGHT;
                cell_d.pend_r = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= CELL_RESET;
        else        cell_q <= cell_d;
    end

    assign own_l  = (cell_q.owner == OWN_LEFT);
    assign own_r  = (cell_q.owner == OWN_RIGHT);
    assign pend_l = cell_q.pend_l;
    assign pend_r = cell_q.pend_r;

endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int NUM_SEM = 8,
    parameter int SEL_W   = $clog2(NUM_SEM),
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '1;
        if (rd_en) rdata_d = {DATA_W{~own[rd_idx]}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '1;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_sel,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int SEL_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r;
    logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;
    logic               rd_en_l, rd_en_r;
    logic [SEL_W-1:0]   rd_idx_l, rd_idx_r;

    logic unused_hi_bits;
    assign unused_hi_bits = ^{l_addr[ADDR_W-1:SEL_W], l_wdata[DATA_W-1:1],
                              r_addr[ADDR_W-1:SEL_W], r_wdata[DATA_W-1:1]};

    sem_port_decode #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W)) u_dec_l (
        .sel(l_sem_sel), .we(l_we), .oe(l_oe),
        .addr_lo(l_addr[SEL_W-1:0]), .token(l_wdata[0]),
        .req(req_l), .rel(rel_l), .rd_en(rd_en_l), .rd_idx(rd_idx_l)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W)) u_dec_r (
        .sel(r_sem_sel), .we(r_we), .oe(r_oe),
        .addr_lo(r_addr[SEL_W-1:0]), .token(r_wdata[0]),
        .req(req_r), .rel(rel_r), .rd_en(rd_en_r), .rd_idx(rd_idx_r)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_token_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l[i]), .rel_l(rel_l[i]),
            .req_r(req_r[i]), .rel_r(rel_r[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .pend_l(pend_l[i]), .pend_r(pend_r[i])
        );
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_l), .rd_idx(rd_idx_l),
        .own(own_l), .rdata(l_rdata)
    );

    sem_read_port #(.NUM_SEM(NUM_SEM), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_r), .rd_idx(rd_idx_r),
        .own(own_r), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sem_sel,
    input logic               l_we,
    input logic               l_oe,
    input logic               r_sem_sel,
    input logic               r_we,
    input logic               r_oe,
    input logic [DATA_W-1:0]  l_rdata,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [NUM_SEM-1:0] pend_l,
    input logic [NUM_SEM-1:0] pend_r,
    input logic [NUM_SEM-1:0] req_l,
    input logic [NUM_SEM-1:0] req_r,
    input logic [NUM_SEM-1:0] rel_l,
    input logic [NUM_SEM-1:0] rel_r
);

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    p_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    p_idle_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(l_sem_sel && l_oe && !l_we) |-> l_rdata == '1);

    p_no_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sem_sel && !r_sem_sel) |=> ($stable(own_l) && $stable(own_r)));

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_lat
        p_left_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_l[i] && !own_r[i] && req_l[i] && req_r[i]) |=> own_l[i]);

        p_handoff_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && rel_l[i] && pend_r[i]) |=> own_r[i]);

        p_handoff_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r[i] && rel_r[i] && pend_l[i]) |=> own_l[i]);

        p_hold_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && !rel_l[i]) |=> own_l[i]);

        p_hold_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r[i] && !rel_r[i]) |=> own_r[i]);
    end

endmodule

bind sem_token_bank sem_token_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_we(l_we), .l_oe(l_oe),
    .r_sem_sel(r_sem_sel), .r_we(r_we), .r_oe(r_oe),
    .l_rdata(l_rdata), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r),
    .req_l(req_l), .req_r(req_r), .rel_l(rel_l), .rel_r(rel_r)
);

// File: tb/sem_token_bank_test.sv
`timescale 1ns/1ps
module sem_token_bank_test;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] HELD = '0;
    localparam logic [DATA_W-1:0] NOT_HELD = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel = 0, l_we = 0, l_oe = 0, r_sel = 0, r_we = 0, r_oe = 0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sem_token_bank uut (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        l_sel = 0; l_we = 0; l_oe = 0; r_sel = 0; r_we = 0; r_oe = 0;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    // one write on one port; right=1 picks the right port
    task automatic wr(input bit right, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        if (right) begin r_sel = 1; r_we = 1; r_addr = a; r_wdata = d; end
        else       begin l_sel = 1; l_we = 1; l_addr = a; l_wdata = d; end
        @(posedge clk); #1;
        clear_all();
    endtask

    task automatic wr_both(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] dl,
                           input logic [DATA_W-1:0] dr);
        @(negedge clk);
        l_sel = 1; l_we = 1; l_addr = a; l_wdata = dl;
        r_sel = 1; r_we = 1; r_addr = a; r_wdata = dr;
        @(posedge clk); #1;
        clear_all();
    endtask

    task automatic rd_both(input logic [ADDR_W-1:0] al, input logic [ADDR_W-1:0] ar,
                           output logic [DATA_W-1:0] vl, output logic [DATA_W-1:0] vr);
        @(negedge clk);
        l_sel = 1; l_oe = 1; l_addr = al;
        r_sel = 1; r_oe = 1; r_addr = ar;
        @(posedge clk); #1;
        vl = l_rdata; vr = r_rdata;
        clear_all();
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] vl, vr;
        chk(l_rdata == NOT_HELD && r_rdata == NOT_HELD, "R1 idle outputs", l_rdata, NOT_HELD);
        for (int i = 0; i < 8; i++) begin
            rd_both(ADDR_W'(i), ADDR_W'(i), vl, vr);
            chk(vl == NOT_HELD && vr == NOT_HELD, "R1 latch free after reset", vl & vr, NOT_HELD);
        end
    endtask

    task automatic t_grant();
        logic [DATA_W-1:0] vl, vr;
        wr(0, 12'd2, 16'h0000);
        rd_both(12'd2, 12'd2, vl, vr);
        chk(vl == HELD, "R2 holder reads zeros", vl, HELD);
        chk(vr == NOT_HELD, "R2 other port reads ones", vr, NOT_HELD);
        wr(0, 12'd2, 16'h0001);
        rd_both(12'd2, 12'd2, vl, vr);
        chk(vl == NOT_HELD && vr == NOT_HELD, "R7 release frees latch", vl & vr, NOT_HELD);
    endtask

    task automatic t_decode();
        logic [DATA_W-1:0] vl, vr;
        wr(1, 12'hA05, 16'hFFFE);
        rd_both(12'h305, 12'hC05, vl, vr);
        chk(vr == HELD, "R3 upper bits ignored on claim", vr, HELD);
        chk(vl == NOT_HELD, "R3 left sees latch 5 held", vl, NOT_HELD);
        rd_both(12'd4, 12'd4, vl, vr);
        chk(vr == NOT_HELD, "R3 neighbour latch untouched", vr, NOT_HELD);
        wr(1, 12'hF05, 16'h0001);
        rd_both(12'd5, 12'd5, vl, vr);
        chk(vr == NOT_HELD, "R3 release via bit 0 only", vr, NOT_HELD);
    endtask

    task automatic t_tie();
        logic [DATA_W-1:0] vl, vr;
        wr_both(12'd3, 16'h0000, 16'h0000);
        rd_both(12'd3, 12'd3, vl, vr);
        chk(vl == HELD, "R5 left wins tie", vl, HELD);
        chk(vr == NOT_HELD, "R4 right not holder too", vr, NOT_HELD);
        wr(0, 12'd3, 16'h0001);
        rd_both(12'd3, 12'd3, vl, vr);
        chk(vr == HELD, "R6 pending right granted on release", vr, HELD);
        chk(vl == NOT_HELD, "R4 left gave up latch", vl, NOT_HELD);
        wr(1, 12'd3, 16'h0001);
    endtask

    task automatic t_handoff();
        logic [DATA_W-1:0] vl, vr;
        wr(1, 12'd6, 16'h0000);
        wr(0, 12'd6, 16'h0000);
        rd_both(12'd6, 12'd6, vl, vr);
        chk(vr == HELD && vl == NOT_HELD, "R6 claim on held latch waits", vl, NOT_HELD);
        wr(1, 12'd6, 16'h0001);
        rd_both(12'd6, 12'd6, vl, vr);
        chk(vl == HELD, "R6 left granted after right release", vl, HELD);
        wr(0, 12'd6, 16'h0001);
        rd_both(12'd6, 12'd6, vl, vr);
        chk(vl == NOT_HELD && vr == NOT_HELD, "R7 latch free after last release", vl & vr, NOT_HELD);
    endtask

    task automatic t_withdraw();
        logic [DATA_W-1:0] vl, vr;
        wr(0, 12'd1, 16'h0000);
        wr(1, 12'd1, 16'h0000);
        wr(1, 12'd1, 16'h0001);
        rd_both(12'd1, 12'd1, vl, vr);
        chk(vl == HELD, "R8 holder unchanged by other release", vl, HELD);
        wr(0, 12'd1, 16'h0001);
        rd_both(12'd1, 12'd1, vl, vr);
        chk(vr == NOT_HELD, "R8 withdrawn claim not granted", vr, NOT_HELD);
    endtask

    task automatic t_ignore();
        logic [DATA_W-1:0] vl, vr;
        @(negedge clk);
        l_sel = 0; l_we = 1; l_addr = 12'd0; l_wdata = 16'h0000;
        @(posedge clk); #1;
        clear_all();
        rd_both(12'd0, 12'd0, vl, vr);
        chk(vl == NOT_HELD, "R9 write without select ignored", vl, NOT_HELD);
        wr(0, 12'd0, 16'h0000);
        @(negedge clk);
        l_sel = 1; l_oe = 0; l_we = 0; l_addr = 12'd0;
        @(posedge clk); #1;
        chk(l_rdata == NOT_HELD, "R9 no read without output enable", l_rdata, NOT_HELD);
        clear_all();
        rd_both(12'd0, 12'd0, vl, vr);
        chk(vl == HELD, "R9 read with enable sees hold", vl, HELD);
        @(posedge clk); #1;
        chk(l_rdata == NOT_HELD, "R9 read data lasts one cycle", l_rdata, NOT_HELD);
        wr(0, 12'd0, 16'h0001);
    endtask

    task automatic t_indep();
        logic [DATA_W-1:0] vl, vr;
        wr(0, 12'd0, 16'h0000);
        wr(1, 12'd7, 16'h0000);
        rd_both(12'd7, 12'd0, vl, vr);
        chk(vl == NOT_HELD && vr == NOT_HELD, "R10 cross reads see other owner", vl & vr, NOT_HELD);
        wr(0, 12'd0, 16'h0001);
        rd_both(12'd0, 12'd7, vl, vr);
        chk(vr == HELD, "R10 release of 0 keeps 7 held", vr, HELD);
        chk(vl == NOT_HELD, "R10 latch 0 freed", vl, NOT_HELD);
        wr(1, 12'd7, 16'h0001);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_grant();
        t_decode();
        t_tie();
        t_handoff();
        t_withdraw();
        t_ignore();
        t_indep();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule